// File: doc/BRIEF.md
# MSI Directory Coherence Controller

This block is the parent side of a two-level coherence system. It owns the backing memory words and a directory. For every address, the directory holds the MSI state recorded for each child cache and a wait entry that says whether a downgrade answer from that child is still outstanding. Each child has two input paths into the block. One carries upgrade requests, which are held at the queue head until the controller dequeues them. The other carries downgrade responses, which are always taken. Each child also has one output path, which carries upgrade responses and downgrade requests.

Each cycle a round-robin selector picks one child's head request. The controller checks the requested level against the recorded states of all siblings. If every sibling is compatible and no wait is pending on that address, it grants the request. Otherwise it leaves the request in place and asks the incompatible siblings to step down. Downgrade responses write dirty data back to memory and update the directory. A wait entry is released only when the answer comes down far enough.

Top module: `dirController`

## Requirements
- R1: After reset every child is recorded in I for every address, no wait is pending, every memory word is zero, no request is dequeued and no output message is valid.
- R2: States are coded I=0, S=1, M=2. M is incompatible with a sibling in S or M, and every other pairing is compatible. An upgrade-to-y request from child c is dequeued (its ready bit is high in that cycle) only if no child has a pending wait on that address and every other child's recorded state is compatible with y. The grant sets c's recorded state to y.
- R3: One cycle after a grant, child c gets a message of kind 0 (upgrade response) with state y and the request address. Data and the has-data flag are carried only if c was recorded in I; otherwise the flag is 0.
- R4: When a request for y is blocked, the target level is I for y=M and S for y=S. Each other child recorded above the target with no pending wait gets a message of kind 1 (downgrade request) with the target state one cycle later, and that child becomes awaited for the target. The request is not dequeued, and no second downgrade request goes to a child whose wait is still pending.
- R5: A downgrade-to-y response from child c writes its data into memory only if c was recorded in M. It then sets c's recorded state to y.
- R6: On that response, c's wait entry for level x is cleared only if x ≥ y in the order M > S > I. A response that stops above the awaited level leaves the wait in place, so requests for that address stay blocked.
- R7: Child responses need no handshake and are taken in every cycle, voluntary ones included. In any cycle with a response on any child, no request is examined and no ready bit is raised.
- R8: Requests are examined round-robin. After the request of child k is examined, the search in the next cycle starts at child k+1, wrapping around.
- R9: At most one request is dequeued per cycle. Each output message appears exactly one cycle after the decision that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CHILD | Head request present, per child |
| reqAddr | input | NUM_CHILD x ADDR_W | Request address, per child |
| reqState | input | NUM_CHILD x 2 | Requested level (1=S, 2=M), per child |
| reqReady | output | NUM_CHILD | Dequeue strobe for the head request |
| respValid | input | NUM_CHILD | Downgrade response present, per child |
| respAddr | input | NUM_CHILD x ADDR_W | Response address |
| respState | input | NUM_CHILD x 2 | Level the child has moved down to |
| respData | input | NUM_CHILD x DATA_W | Write-back word |
| msgValid | output | NUM_CHILD | Parent-to-child message valid |
| msgKind | output | NUM_CHILD | 0 upgrade response, 1 downgrade request |
| msgAddr | output | NUM_CHILD x ADDR_W | Message address |
| msgState | output | NUM_CHILD x 2 | Granted or target level |
| msgData | output | NUM_CHILD x DATA_W | Memory word (zero when no data) |
| msgHasData | output | NUM_CHILD | Message carries memory data |

## Verification
On every cycle, the assertions check that a grant never coincides with an incompatible sibling or a pending wait, and that downgrade requests go only to children above the target with no wait. They also check that responses stall request handling, that at most one request is dequeued, and that every upgrade message follows a dequeue. Only the bench's scenarios can show the end-to-end effects. These are the data a child actually receives after dirty write-backs, a wait surviving a response that stops too high, the release that comes later, and the rotation of the selector between competing children.

// File: rtl/dirPkg.sv
package dirPkg;
  typedef logic [1:0] mstate_t;
  localparam mstate_t ST_I = 2'd0;
  localparam mstate_t ST_S = 2'd1;
  localparam mstate_t ST_M = 2'd2;

  localparam logic KIND_UP = 1'b0;
  localparam logic KIND_DN = 1'b1;

  typedef struct packed {
    logic    grantEn;
    logic    dnEn;
    mstate_t upState;
    mstate_t dnTarget;
  } strobe_t;
endpackage

// File: rtl/dirCtrl.sv
module dirCtrl
  import dirPkg::*;
#(
  parameter int NUM_CHILD = 2,
  parameter int ADDR_W    = 4,
  localparam int CHILD_W  = (NUM_CHILD > 1) ? $clog2(NUM_CHILD) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_CHILD-1:0]               reqValid,
  input  logic [NUM_CHILD-1:0][ADDR_W-1:0]   reqAddr,
  input  logic [NUM_CHILD-1:0][1:0]          reqState,
  input  logic                               anyResp,
  input  logic [NUM_CHILD-1:0][1:0]          curState,
  input  logic [NUM_CHILD-1:0]               curWait,
  output logic [ADDR_W-1:0]                  lookAddr,
  output logic [NUM_CHILD-1:0]               reqReady,
  output logic [NUM_CHILD-1:0]               grantMask,
  output logic [NUM_CHILD-1:0]               dnMask,
  output strobe_t                            strobe
);
  logic [CHILD_W-1:0] ptr;
  logic [CHILD_W-1:0] sel;
  logic               found;
  logic               examine;
  logic               allOk;
  mstate_t            wantState;
  mstate_t            target;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NUM_CHILD; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= NUM_CHILD) idx = idx - NUM_CHILD;
      if (!found && reqValid[idx]) begin
        found = 1'b1;
        sel   = CHILD_W'(idx);
      end
    end
  end

  assign examine   = found && !anyResp;
  assign lookAddr  = reqAddr[sel];
  assign wantState = reqState[sel];
  assign target    = (wantState == ST_M) ? ST_I : ST_S;

  always_comb begin
    allOk = (curWait == '0);
    for (int c = 0; c < NUM_CHILD; c++) begin
      if (c != int'(sel)) begin
        if (wantState == ST_M && curState[c] != ST_I) allOk = 1'b0;
        if (wantState == ST_S && curState[c] == ST_M) allOk = 1'b0;
      end
    end
  end

  always_comb begin
    grantMask = '0;
    dnMask    = '0;
    if (examine && allOk) grantMask[sel] = 1'b1;
    for (int c = 0; c < NUM_CHILD; c++) begin
      if (examine && !allOk && c != int'(sel) &&
          curState[c] > target && !curWait[c])
        dnMask[c] = 1'b1;
    end
  end

  assign reqReady         = grantMask;
  assign strobe.grantEn   = |grantMask;
  assign strobe.dnEn      = |dnMask;
  assign strobe.upState   = wantState;
  assign strobe.dnTarget  = target;

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (examine) ptr <= (int'(sel) == NUM_CHILD - 1) ? '0 : sel + 1'b1;
  end
endmodule

// File: rtl/dirData.sv
module dirData
  import dirPkg::*;
#(
  parameter int NUM_CHILD = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_CHILD-1:0]               respValid,
  input  logic [NUM_CHILD-1:0][ADDR_W-1:0]   respAddr,
  input  logic [NUM_CHILD-1:0][1:0]          respState,
  input  logic [NUM_CHILD-1:0][DATA_W-1:0]   respData,
  input  logic [ADDR_W-1:0]                  lookAddr,
  input  logic [NUM_CHILD-1:0]               grantMask,
  input  logic [NUM_CHILD-1:0]               dnMask,
  input  strobe_t                            strobe,
  output logic [NUM_CHILD-1:0][1:0]          curState,
  output logic [NUM_CHILD-1:0]               curWait,
  output logic [NUM_CHILD-1:0]               msgValid,
  output logic [NUM_CHILD-1:0]               msgKind,
  output logic [NUM_CHILD-1:0][ADDR_W-1:0]   msgAddr,
  output logic [NUM_CHILD-1:0][1:0]          msgState,
  output logic [NUM_CHILD-1:0][DATA_W-1:0]   msgData,
  output logic [NUM_CHILD-1:0]               msgHasData
);
  mstate_t             dirState [DEPTH][NUM_CHILD];
  logic                waitOn   [DEPTH][NUM_CHILD];
  mstate_t             waitLvl  [DEPTH][NUM_CHILD];
  logic [DATA_W-1:0]   mem      [DEPTH];

  always_comb begin
    for (int c = 0; c < NUM_CHILD; c++) begin
      curState[c] = dirState[lookAddr][c];
      curWait[c]  = waitOn[lookAddr][c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) begin
        mem[a] <= '0;
        for (int c = 0; c < NUM_CHILD; c++) begin
          dirState[a][c] <= ST_I;
          waitOn[a][c]   <= 1'b0;
          waitLvl[a][c]  <= ST_I;
        end
      end
    end else begin
      for (int c = 0; c < NUM_CHILD; c++) begin
        if (respValid[c]) begin
          if (dirState[respAddr[c]][c] == ST_M) mem[respAddr[c]] <= respData[c];
          dirState[respAddr[c]][c] <= respState[c];
          if (waitOn[respAddr[c]][c] && waitLvl[respAddr[c]][c] >= respState[c])
            waitOn[respAddr[c]][c] <= 1'b0;
        end
        if (grantMask[c]) dirState[lookAddr][c] <= strobe.upState;
        if (dnMask[c]) begin
          waitOn[lookAddr][c]  <= 1'b1;
          waitLvl[lookAddr][c] <= strobe.dnTarget;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid   <= '0;
      msgKind    <= '0;
      msgAddr    <= '0;
      msgState   <= '0;
      msgData    <= '0;
      msgHasData <= '0;
    end else begin
      for (int c = 0; c < NUM_CHILD; c++) begin
        msgValid[c]   <= grantMask[c] | dnMask[c];
        msgKind[c]    <= dnMask[c] ? KIND_DN : KIND_UP;
        msgAddr[c]    <= lookAddr;
        msgState[c]   <= grantMask[c] ? strobe.upState : strobe.dnTarget;
        msgHasData[c] <= grantMask[c] && (curState[c] == ST_I);
        msgData[c]    <= (grantMask[c] && curState[c] == ST_I) ? mem[lookAddr] : '0;
      end
    end
  end
endmodule

// File: rtl/dirController.sv
module dirController
  import dirPkg::*;
#(
  parameter int NUM_CHILD = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_CHILD-1:0]               reqValid,
  input  logic [NUM_CHILD-1:0][ADDR_W-1:0]   reqAddr,
  input  logic [NUM_CHILD-1:0][1:0]          reqState,
  output logic [NUM_CHILD-1:0]               reqReady,
  input  logic [NUM_CHILD-1:0]               respValid,
  input  logic [NUM_CHILD-1:0][ADDR_W-1:0]   respAddr,
  input  logic [NUM_CHILD-1:0][1:0]          respState,
  input  logic [NUM_CHILD-1:0][DATA_W-1:0]   respData,
  output logic [NUM_CHILD-1:0]               msgValid,
  output logic [NUM_CHILD-1:0]               msgKind,
  output logic [NUM_CHILD-1:0][ADDR_W-1:0]   msgAddr,
  output logic [NUM_CHILD-1:0][1:0]          msgState,
  output logic [NUM_CHILD-1:0][DATA_W-1:0]   msgData,
  output logic [NUM_CHILD-1:0]               msgHasData
);
  logic [ADDR_W-1:0]          lookAddr;
  logic [NUM_CHILD-1:0][1:0]  curState;
  logic [NUM_CHILD-1:0]       curWait;
  logic [NUM_CHILD-1:0]       grantMask;
  logic [NUM_CHILD-1:0]       dnMask;
  strobe_t                    strobe;

  dirCtrl #(.NUM_CHILD(NUM_CHILD), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqState(reqState), .anyResp(|respValid), .curState(curState),
    .curWait(curWait), .lookAddr(lookAddr), .reqReady(reqReady),
    .grantMask(grantMask), .dnMask(dnMask), .strobe(strobe)
  );

  dirData #(.NUM_CHILD(NUM_CHILD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .respValid(respValid), .respAddr(respAddr),
    .respState(respState), .respData(respData), .lookAddr(lookAddr),
    .grantMask(grantMask), .dnMask(dnMask), .strobe(strobe),
    .curState(curState), .curWait(curWait), .msgValid(msgValid),
    .msgKind(msgKind), .msgAddr(msgAddr), .msgState(msgState),
    .msgData(msgData), .msgHasData(msgHasData)
  );
endmodule

// File: rtl/dirChecker.sv
module dirChecker
  import dirPkg::*;
#(
  parameter int NUM_CHILD = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_CHILD-1:0]       reqReady,
  input logic [NUM_CHILD-1:0]       respValid,
  input logic [NUM_CHILD-1:0]       grantMask,
  input logic [NUM_CHILD-1:0]       dnMask,
  input logic [NUM_CHILD-1:0][1:0]  curState,
  input logic [NUM_CHILD-1:0]       curWait,
  input strobe_t                    strobe,
  input logic [NUM_CHILD-1:0]       msgValid,
  input logic [NUM_CHILD-1:0]       msgKind
);
  // R9: never more than one dequeue per cycle
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

  // R7: a response cycle examines no request
  a_r7_resp_priority: assert property (@(posedge clk) disable iff (!rstN)
    (|respValid) |-> (reqReady == '0));

  for (genvar c = 0; c < NUM_CHILD; c++) begin : gChild
    // R4: downgrade only above target, never on a pending wait, never with a grant
    a_r4_dn_target: assert property (@(posedge clk) disable iff (!rstN)
      dnMask[c] |-> (curState[c] > strobe.dnTarget) && !curWait[c] && (reqReady == '0));

    // R9: an upgrade message follows a dequeue of the same child
    a_r9_msg_follows: assert property (@(posedge clk) disable iff (!rstN)
      (msgValid[c] && msgKind[c] == KIND_UP) |-> $past(reqReady[c]));

    // R2: a grant sees no pending wait
    a_r2_no_wait: assert property (@(posedge clk) disable iff (!rstN)
      grantMask[c] |-> (curWait == '0));

    for (genvar o = 0; o < NUM_CHILD; o++) begin : gOther
      if (o != c) begin : gPair
        // R2: granting M requires every sibling in I
        a_r2_m_compat: assert property (@(posedge clk) disable iff (!rstN)
          (grantMask[c] && strobe.upState == ST_M) |-> (curState[o] == ST_I));
        // R2: granting S requires no sibling in M
        a_r2_s_compat: assert property (@(posedge clk) disable iff (!rstN)
          (grantMask[c] && strobe.upState == ST_S) |-> (curState[o] != ST_M));
      end
    end
  end
endmodule

bind dirController dirChecker #(.NUM_CHILD(NUM_CHILD)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .respValid(respValid),
  .grantMask(grantMask), .dnMask(dnMask), .curState(curState),
  .curWait(curWait), .strobe(strobe), .msgValid(msgValid), .msgKind(msgKind)
);

// File: tb/dirController_test.sv
module dirController_test;
  localparam int NC = 2;
  localparam int AW = 4;
  localparam int DW = 32;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [NC-1:0]        reqValid = '0;
  logic [NC-1:0][AW-1:0] reqAddr = '0;
  logic [NC-1:0][1:0]   reqState = '0;
  logic [NC-1:0]        reqReady;
  logic [NC-1:0]        respValid = '0;
  logic [NC-1:0][AW-1:0] respAddr = '0;
  logic [NC-1:0][1:0]   respState = '0;
  logic [NC-1:0][DW-1:0] respData = '0;
  logic [NC-1:0]        msgValid;
  logic [NC-1:0]        msgKind;
  logic [NC-1:0][AW-1:0] msgAddr;
  logic [NC-1:0][1:0]   msgState;
  logic [NC-1:0][DW-1:0] msgData;
  logic [NC-1:0]        msgHasData;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dirController #(.NUM_CHILD(NC), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqState(reqState), .reqReady(reqReady), .respValid(respValid),
    .respAddr(respAddr), .respState(respState), .respData(respData),
    .msgValid(msgValid), .msgKind(msgKind), .msgAddr(msgAddr),
    .msgState(msgState), .msgData(msgData), .msgHasData(msgHasData)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // op: 1 request, 2 response. States I=0 S=1 M=2. Kind 0 up, 1 down.
  typedef struct packed {
    logic [1:0]  op;
    logic        ch;
    logic [3:0]  addr;
    logic [1:0]  st;
    logic [31:0] data;
    logic [1:0]  expReady;
    logic [1:0]  expValid;
    logic        expKind;
    logic [1:0]  expSt;
    logic        expHas;
    logic [31:0] expData;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 4'd3, 2'd2, 32'h0,         2'b01, 2'b01, 1'b0, 2'd2, 1'b1, 32'h0},         // R2 R3 grant M
    '{2'd2, 1'b0, 4'd3, 2'd0, 32'hA5A50001,  2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R5 dirty write-back
    '{2'd1, 1'b1, 4'd3, 2'd1, 32'h0,         2'b10, 2'b10, 1'b0, 2'd1, 1'b1, 32'hA5A50001},  // R3 data from memory
    '{2'd1, 1'b0, 4'd3, 2'd1, 32'h0,         2'b01, 2'b01, 1'b0, 2'd1, 1'b1, 32'hA5A50001},  // R2 S with S
    '{2'd1, 1'b0, 4'd3, 2'd2, 32'h0,         2'b00, 2'b10, 1'b1, 2'd0, 1'b0, 32'h0},         // R4 down to I
    '{2'd1, 1'b0, 4'd3, 2'd2, 32'h0,         2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R4 no resend
    '{2'd2, 1'b1, 4'd3, 2'd0, 32'h0000DEAD,  2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R5 clean, no write
    '{2'd1, 1'b0, 4'd3, 2'd2, 32'h0,         2'b01, 2'b01, 1'b0, 2'd2, 1'b0, 32'h0},         // R3 S to M no data
    '{2'd1, 1'b1, 4'd3, 2'd1, 32'h0,         2'b00, 2'b01, 1'b1, 2'd1, 1'b0, 32'h0},         // R4 down to S
    '{2'd2, 1'b0, 4'd3, 2'd1, 32'h12345678,  2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R5 write from M
    '{2'd1, 1'b1, 4'd3, 2'd1, 32'h0,         2'b10, 2'b10, 1'b0, 2'd1, 1'b1, 32'h12345678},  // R3 sees new data
    '{2'd1, 1'b0, 4'd8, 2'd2, 32'h0,         2'b01, 2'b01, 1'b0, 2'd2, 1'b1, 32'h0},         // R2 grant M
    '{2'd1, 1'b1, 4'd8, 2'd2, 32'h0,         2'b00, 2'b01, 1'b1, 2'd0, 1'b0, 32'h0},         // R4 down to I
    '{2'd2, 1'b0, 4'd8, 2'd1, 32'h0BADF00D,  2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R6 stops at S
    '{2'd1, 1'b1, 4'd8, 2'd2, 32'h0,         2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R6 wait still held
    '{2'd2, 1'b0, 4'd8, 2'd0, 32'h00001111,  2'b00, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0},         // R6 release
    '{2'd1, 1'b1, 4'd8, 2'd2, 32'h0,         2'b10, 2'b10, 1'b0, 2'd2, 1'b1, 32'h0BADF00D}   // R6 R5 grant after
  };

  task automatic idle();
    reqValid  = '0;
    respValid = '0;
  endtask

  task automatic checkMsg(input int v, input vec_t e);
    chk(msgValid == e.expValid, $sformatf("R9 vec %0d msgValid", v), 32'(msgValid), 32'(e.expValid));
    for (int c = 0; c < NC; c++) begin
      if (e.expValid[c]) begin
        chk(msgKind[c] == e.expKind, $sformatf("R4 vec %0d kind", v), 32'(msgKind[c]), 32'(e.expKind));
        chk(msgState[c] == e.expSt, $sformatf("R3 vec %0d state", v), 32'(msgState[c]), 32'(e.expSt));
        chk(msgHasData[c] == e.expHas, $sformatf("R3 vec %0d hasData", v), 32'(msgHasData[c]), 32'(e.expHas));
        chk(msgData[c] == e.expData, $sformatf("R5 vec %0d data", v), msgData[c], e.expData);
        chk(msgAddr[c] == e.addr, $sformatf("R3 vec %0d addr", v), 32'(msgAddr[c]), 32'(e.addr));
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(reqReady == '0, "R1 reqReady in reset", 32'(reqReady), 0);
    chk(msgValid == '0, "R1 msgValid in reset", 32'(msgValid), 0);
    rstN = 1'b1;

    foreach (VEC[v]) begin
      vec_t e;
      e = VEC[v];
      @(negedge clk);
      idle();
      if (e.op == 2'd1) begin
        reqValid[e.ch] = 1'b1; reqAddr[e.ch] = e.addr; reqState[e.ch] = e.st;
      end else if (e.op == 2'd2) begin
        respValid[e.ch] = 1'b1; respAddr[e.ch] = e.addr;
        respState[e.ch] = e.st; respData[e.ch] = e.data;
      end
      #1;
      chk(reqReady == e.expReady, $sformatf("R2 vec %0d reqReady", v), 32'(reqReady), 32'(e.expReady));
      @(posedge clk);
      #1;
      checkMsg(v, e);
    end

    // R7: request alongside a response is not examined
    @(negedge clk);
    idle();
    reqValid[0] = 1'b1; reqAddr[0] = 4'd10; reqState[0] = 2'd1;
    respValid[1] = 1'b1; respAddr[1] = 4'd10; respState[1] = 2'd0; respData[1] = 32'h77;
    #1;
    chk(reqReady == 2'b00, "R7 ready during response", 32'(reqReady), 0);
    @(posedge clk); #1;
    chk(msgValid == 2'b00, "R7 no message", 32'(msgValid), 0);
    @(negedge clk);
    respValid = '0;
    #1;
    chk(reqReady == 2'b01, "R7 granted after response", 32'(reqReady), 1);
    @(posedge clk); #1;
    chk(msgData[0] == 32'h0 && msgHasData[0], "R1 unwritten word is zero", msgData[0], 0);

    // R8: both children compete; the pointer now starts at child 1
    @(negedge clk);
    idle();
    reqValid = 2'b11;
    reqAddr[0] = 4'd5; reqState[0] = 2'd1;
    reqAddr[1] = 4'd6; reqState[1] = 2'd1;
    #1;
    chk(reqReady == 2'b10, "R8 rotation picks child 1", 32'(reqReady), 2);
    @(posedge clk); #1;
    chk(msgValid == 2'b10 && msgAddr[1] == 4'd6, "R8 message to child 1", 32'(msgValid), 2);
    @(negedge clk);
    reqAddr[1] = 4'd7;
    #1;
    chk(reqReady == 2'b01, "R8 rotation picks child 0", 32'(reqReady), 1);
    @(posedge clk); #1;
    chk(msgValid == 2'b01 && msgAddr[0] == 4'd5, "R8 message to child 0", 32'(msgValid), 1);
    @(negedge clk);
    idle();
    @(posedge clk); #1;
    chk(msgValid == 2'b00, "R9 message lasts one cycle", 32'(msgValid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule